// File: doc/BRIEF.md
# Status-Code-Triggered Pulse Sequencer

This block watches an 8-bit boot progress code that a target processor drives onto a status port. It runs a fixed sequence against it. A first code asserts a clock-slowdown control line. A later code starts an offset counter. When that counter matches a programmed compare value, the block emits one short active-high pulse on a reset-style output. It then keeps the slowdown line asserted for a programmed hold time, releases it and raises a completion flag.

The status port is asynchronous to the reference clock. It passes through a two-flop synchronizer. A code counts only once two successive synchronised samples agree. A failure code from the target ends the sequence with a failure flag. Any code that arrives out of the expected order ends the sequence with an error flag. In both cases every control output is released. The enable input turns the whole block off synchronously.

Top module: `status_pulse_seq`

## Requirements
- R1: While rst_n is low or enable is low, every output is 0. Enable low returns the sequencer to idle and clears all result flags, so a later code 8'h39 seen while idle does nothing.
- R2: A status value takes effect only after it has passed two synchroniser flops and the last two synchronised samples agree. The sequencer state changes on the fourth rising edge after the value is applied. A value held for one cycle is never acted on.
- R3: In idle, a qualified code 8'h36 asserts slow_o. The sequence stays in this phase while the code remains 8'h36.
- R4: In the slowdown phase, the first qualified code 8'h39 starts the offset counter from zero. armed_o is high while the counter runs.
- R5: The pulse starts after exactly cmp_val+1 cycles of armed_o, which is the cycle after the counter equals cmp_val.
- R6: pulse_o stays high for exactly PULSE_CYC consecutive cycles. The default of 5 gives about 100 ns at a 48 MHz reference.
- R7: After the pulse, slow_o stays high for hold_val+1 more cycles and then falls together with the rise of done_o.
- R8: At most one pulse is emitted per sequence. Once the pulse has started, any code other than 8'hAD is ignored.
- R9: A qualified code 8'hAD in any active phase sets fail_o, releases slow_o, pulse_o and armed_o, and returns to idle.
- R10: An unexpected code sets err_o and returns to idle with all outputs released. In the slowdown phase, that is any code other than 8'h36, 8'h39 or 8'hAD. While counting, it is any code other than 8'h39 or 8'hAD.
- R11: done_o, fail_o and err_o are sticky and at most one of them is high. They clear when a new 8'h36 starts a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable; low forces idle |
| status_in | input | 8 | Boot status code from the target, asynchronous |
| cmp_val | input | 16 | Offset compare value for pulse placement |
| hold_val | input | 16 | Hold time after the pulse, in cycles minus one |
| slow_o | output | 1 | Clock-slowdown control line |
| pulse_o | output | 1 | Narrow reset-style pulse |
| armed_o | output | 1 | Offset counter running |
| done_o | output | 1 | Sequence finished normally (sticky) |
| fail_o | output | 1 | Failure code seen (sticky) |
| err_o | output | 1 | Out-of-order code seen (sticky) |

## Verification
The assertions assume that cmp_val and hold_val are held steady for the whole of a sequence. They also assume that the status port changes less often than the qualifier delay, so each intended code is seen stable for at least two synchronised samples. The stimulus changes the compare and hold values only between sequences, while the block is idle. It keeps each intended code for eight or more cycles. The only exception is one deliberate single-cycle value, which tests that short values are rejected.

// File: rtl/sps_pkg.sv
package sps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SLOW  = 3'd1,
    ST_COUNT = 3'd2,
    ST_PULSE = 3'd3,
    ST_HOLD  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_DONE = 2'd1,
    RES_FAIL = 2'd2,
    RES_ERR  = 2'd3
  } seq_result_e;

endpackage

// File: rtl/sps_code_filter.sv
module sps_code_filter #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] raw_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_vld_o
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0][CODE_W-1:0] stage_q;
  logic [DEPTH-1:0][CODE_W-1:0] stage_d;

  // shift chain: stage 0 samples the pin, the last stage is the compared copy
  always_comb begin
    stage_d[0] = raw_i;
    for (int i = 1; i < DEPTH; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign code_o     = stage_q[DEPTH-1];
  assign code_vld_o = (stage_q[DEPTH-1] == stage_q[DEPTH-2]);

endmodule

// File: rtl/sps_timer.sv
module sps_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sps_seq_ctrl.sv
module sps_seq_ctrl
  import sps_pkg::*;
#(
  parameter int                CODE_W    = 8,
  parameter int                CNT_W     = 16,
  parameter int                PULSE_CYC = 5,
  parameter logic [CODE_W-1:0] CODE_SLOW = 8'h36,
  parameter logic [CODE_W-1:0] CODE_ARM  = 8'h39,
  parameter logic [CODE_W-1:0] CODE_FAIL = 8'hAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_vld_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cmp_val_i,
  input  logic [CNT_W-1:0]  hold_val_i,
  output logic              tmr_clr_o,
  output logic              tmr_inc_o,
  output logic              slow_o,
  output logic              pulse_o,
  output logic              armed_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              err_o
);

  localparam logic [CNT_W-1:0] PW_LAST = CNT_W'(PULSE_CYC - 1);

  seq_state_e  st_q, st_d;
  seq_result_e res_q, res_d;
  logic        upd_en;
  logic        see_slow, see_arm, see_fail;

  always_comb begin
    see_slow = code_vld_i && (code_i == CODE_SLOW);
    see_arm  = code_vld_i && (code_i == CODE_ARM);
    see_fail = code_vld_i && (code_i == CODE_FAIL);
    st_d     = st_q;
    res_d    = res_q;
    unique case (st_q)
      ST_IDLE: begin
        if (see_slow) begin
          st_d  = ST_SLOW;
          res_d = RES_NONE;
        end
      end
      ST_SLOW: begin
        if (see_fail) begin
          st_d  = ST_IDLE;
          res_d = RES_FAIL;
        end else if (see_arm) begin
          st_d = ST_COUNT;
        end else if (code_vld_i && !see_slow) begin
          st_d  = ST_IDLE;
          res_d = RES_ERR;
        end
      end
      ST_COUNT: begin
        if (see_fail) begin
          st_d  = ST_IDLE;
          res_d = RES_FAIL;
        end else if (code_vld_i && !see_arm) begin
          st_d  = ST_IDLE;
          res_d = RES_ERR;
        end else if (cnt_i == cmp_val_i) begin
          st_d = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (see_fail) begin
          st_d  = ST_IDLE;
          res_d = RES_FAIL;
        end else if (cnt_i == PW_LAST) begin
          st_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (see_fail) begin
          st_d  = ST_IDLE;
          res_d = RES_FAIL;
        end else if (cnt_i == hold_val_i) begin
          st_d  = ST_IDLE;
          res_d = RES_DONE;
        end
      end
      default: begin
        st_d  = ST_IDLE;
        res_d = RES_NONE;
      end
    endcase
    if (!enable_i) begin
      st_d  = ST_IDLE;
      res_d = RES_NONE;
    end
    upd_en    = (st_d != st_q) || (res_d != res_q);
    tmr_clr_o = (st_d != st_q) || (st_q == ST_IDLE);
    tmr_inc_o = !tmr_clr_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      res_q <= RES_NONE;
    end else if (upd_en) begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  assign slow_o  = enable_i && (st_q != ST_IDLE);
  assign pulse_o = enable_i && (st_q == ST_PULSE);
  assign armed_o = enable_i && (st_q == ST_COUNT);
  assign done_o  = enable_i && (res_q == RES_DONE);
  assign fail_o  = enable_i && (res_q == RES_FAIL);
  assign err_o   = enable_i && (res_q == RES_ERR);

  // checker state: a pulse has already been issued in this sequence
  logic in_pulse;
  logic fired_q;
  assign in_pulse = (st_q == ST_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
    end else if (st_q == ST_IDLE) begin
      fired_q <= 1'b0;
    end else if (in_pulse) begin
      fired_q <= 1'b1;
    end
  end

  a_r1_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (st_q == ST_IDLE));

  a_r5_fire_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pulse) |-> ($past(cnt_i) == $past(cmp_val_i)));

  a_r6_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    in_pulse |-> (cnt_i < CNT_W'(PULSE_CYC)));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_pulse) |-> !fired_q);

  a_r7_done_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(st_q) == ST_HOLD) && !slow_o);

  a_r9_fail_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (!slow_o && !pulse_o && !armed_o));

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done_o, fail_o, err_o}) <= 1);

endmodule

// File: rtl/status_pulse_seq.sv
module status_pulse_seq #(
  parameter int                CODE_W      = 8,
  parameter int                CNT_W       = 16,
  parameter int                SYNC_STAGES = 2,
  parameter int                PULSE_CYC   = 5,
  parameter logic [CODE_W-1:0] CODE_SLOW   = 8'h36,
  parameter logic [CODE_W-1:0] CODE_ARM    = 8'h39,
  parameter logic [CODE_W-1:0] CODE_FAIL   = 8'hAD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] status_in,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic [CNT_W-1:0]  hold_val,
  output logic              slow_o,
  output logic              pulse_o,
  output logic              armed_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              err_o
);

  logic [CODE_W-1:0] code;
  logic              code_vld;
  logic [CNT_W-1:0]  cnt;
  logic              tmr_clr;
  logic              tmr_inc;

  sps_code_filter #(
    .CODE_W      (CODE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .raw_i      (status_in),
    .code_o     (code),
    .code_vld_o (code_vld)
  );

  sps_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (tmr_clr),
    .inc_i (tmr_inc),
    .cnt_o (cnt)
  );

  sps_seq_ctrl #(
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W),
    .PULSE_CYC (PULSE_CYC),
    .CODE_SLOW (CODE_SLOW),
    .CODE_ARM  (CODE_ARM),
    .CODE_FAIL (CODE_FAIL)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable),
    .code_i     (code),
    .code_vld_i (code_vld),
    .cnt_i      (cnt),
    .cmp_val_i  (cmp_val),
    .hold_val_i (hold_val),
    .tmr_clr_o  (tmr_clr),
    .tmr_inc_o  (tmr_inc),
    .slow_o     (slow_o),
    .pulse_o    (pulse_o),
    .armed_o    (armed_o),
    .done_o     (done_o),
    .fail_o     (fail_o),
    .err_o      (err_o)
  );

endmodule

// File: tb/status_pulse_seq_test.sv
`timescale 1ns/1ps
module status_pulse_seq_test;

  localparam int CLK_PERIOD = 20;
  localparam int PW         = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [7:0]  status_in;
  logic [15:0] cmp_val;
  logic [15:0] hold_val;
  logic        slow_o, pulse_o, armed_o, done_o, fail_o, err_o;

  int vectors     = 0;
  int miscompares = 0;
  int cycles      = 0;

  status_pulse_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .status_in (status_in),
    .cmp_val   (cmp_val),
    .hold_val  (hold_val),
    .slow_o    (slow_o),
    .pulse_o   (pulse_o),
    .armed_o   (armed_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .err_o     (err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: phase 0 idle, 1 slow, 2 count, 3 pulse, 4 hold
  int         ph;
  int         n;
  bit         m_done, m_fail, m_err;
  logic [7:0] hist[$];

  always @(posedge clk or negedge rst_n) begin : model
    bit         vld;
    logic [7:0] c;
    int         nph;
    if (!rst_n) begin
      ph = 0; n = 0; m_done = 0; m_fail = 0; m_err = 0;
      hist = '{8'h00, 8'h00, 8'h00};
    end else begin
      vld = (hist[1] == hist[2]);
      c   = hist[2];
      if (!enable) begin
        ph = 0; n = 0; m_done = 0; m_fail = 0; m_err = 0;
      end else begin
        nph = ph;
        case (ph)
          0: if (vld && c == 8'h36) begin nph = 1; m_done = 0; m_fail = 0; m_err = 0; end
          1: if (vld && c == 8'hAD) begin nph = 0; m_fail = 1; end
             else if (vld && c == 8'h39) nph = 2;
             else if (vld && c != 8'h36) begin nph = 0; m_err = 1; end
          2: if (vld && c == 8'hAD) begin nph = 0; m_fail = 1; end
             else if (vld && c != 8'h39) begin nph = 0; m_err = 1; end
             else if (n == int'(cmp_val)) nph = 3;
          3: if (vld && c == 8'hAD) begin nph = 0; m_fail = 1; end
             else if (n == PW - 1) nph = 4;
          4: if (vld && c == 8'hAD) begin nph = 0; m_fail = 1; end
             else if (n == int'(hold_val)) begin nph = 0; m_done = 1; end
          default: nph = 0;
        endcase
        if (nph != ph || ph == 0) n = 0; else n = n + 1;
        ph = nph;
      end
      hist.push_front(status_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model, plus pulse placement monitors
  logic pulse_prev = 1'b0;
  int   armed_run  = 0;
  int   pw_run     = 0;
  int   pulses_seen = 0;

  always @(negedge clk) begin
    bit en;
    en = (rst_n === 1'b1) && (enable === 1'b1);
    check(slow_o  === (en && ph != 0),  "R3 slow_o",  int'(slow_o),  int'(en && ph != 0));
    check(armed_o === (en && ph == 2),  "R4 armed_o", int'(armed_o), int'(en && ph == 2));
    check(pulse_o === (en && ph == 3),  "R5 pulse_o", int'(pulse_o), int'(en && ph == 3));
    check(done_o  === (en && m_done),   "R7 done_o",  int'(done_o),  int'(en && m_done));
    check(fail_o  === (en && m_fail),   "R9 fail_o",  int'(fail_o),  int'(en && m_fail));
    check(err_o   === (en && m_err),    "R10 err_o",  int'(err_o),   int'(en && m_err));
    if (rst_n === 1'b1) begin
      if (pulse_o && !pulse_prev) begin
        pulses_seen++;
        check(armed_run == int'(cmp_val) + 1, "R5 offset", armed_run, int'(cmp_val) + 1);
      end
      if (armed_o) armed_run++; else if (!pulse_o) armed_run = 0;
      if (pulse_o) pw_run++;
      if (!pulse_o && pulse_prev) begin
        check(pw_run == PW, "R6 width", pw_run, PW);
        pw_run = 0;
      end
      pulse_prev = pulse_o;
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic drive(input logic [7:0] code, input int cyc);
    status_in = code;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; status_in = 8'h00;
    cmp_val = 16'd10; hold_val = 16'd20;
    repeat (3) @(negedge clk);
    check({slow_o, pulse_o, armed_o, done_o, fail_o, err_o} == 6'b0, "R1 reset",
          int'({slow_o, pulse_o, armed_o, done_o, fail_o, err_o}), 0);
    rst_n = 1'b1;
    drive(8'h00, 6);

    // normal run, codes after the pulse ignored
    pulses_seen = 0;
    drive(8'h36, 10);
    check(slow_o == 1'b1, "R3 slow on", int'(slow_o), 1);
    drive(8'h39, 20);
    drive(8'h3A, 30);
    drive(8'h39, 10);
    check(done_o == 1'b1, "R7 done", int'(done_o), 1);
    check(pulses_seen == 1, "R8 one pulse", pulses_seen, 1);

    // zero compare and zero hold, flags cleared on restart
    cmp_val = 16'd0; hold_val = 16'd0; pulses_seen = 0;
    drive(8'h36, 8);
    check(done_o == 1'b0, "R11 flag cleared", int'(done_o), 0);
    drive(8'h39, 15);
    drive(8'h00, 5);
    check(done_o == 1'b1 && pulses_seen == 1, "R7 zero hold", pulses_seen, 1);

    // one-cycle blip rejected, then failure code while counting
    cmp_val = 16'd50;
    drive(8'h36, 8);
    drive(8'h39, 1);
    drive(8'h36, 10);
    check(armed_o == 1'b0 && slow_o == 1'b1, "R2 blip", int'(armed_o), 0);
    drive(8'h39, 20);
    drive(8'hAD, 10);
    check(fail_o == 1'b1 && slow_o == 1'b0, "R9 fail", int'(fail_o), 1);

    // unexpected code in the slowdown phase
    drive(8'h36, 8);
    check(fail_o == 1'b0, "R11 fail cleared", int'(fail_o), 0);
    drive(8'h50, 10);
    check(err_o == 1'b1 && slow_o == 1'b0, "R10 slow phase", int'(err_o), 1);

    // unexpected code while counting
    cmp_val = 16'd30;
    drive(8'h36, 8);
    drive(8'h39, 10);
    drive(8'h37, 10);
    check(err_o == 1'b1 && armed_o == 1'b0, "R10 count phase", int'(err_o), 1);

    // failure code during hold
    cmp_val = 16'd5; hold_val = 16'd100; pulses_seen = 0;
    drive(8'h36, 8);
    drive(8'h39, 20);
    drive(8'hAD, 10);
    check(fail_o == 1'b1 && pulses_seen == 1, "R9 fail in hold", pulses_seen, 1);

    // enable dropped mid-count
    cmp_val = 16'd40;
    drive(8'h36, 8);
    drive(8'h39, 10);
    enable = 1'b0;
    @(negedge clk);
    check(slow_o == 1'b0 && armed_o == 1'b0, "R1 enable low", int'(slow_o), 0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    check(slow_o == 1'b0 && fail_o == 1'b0, "R1 idle after enable", int'(slow_o), 0);
    drive(8'h00, 5);

    finish_run();
  end

endmodule